// File: doc/BRIEF.md
# Coin-Accumulating Release Controller

This block is a synchronous state machine that sits behind a single coin slot taking five-cent and ten-cent coins. It keeps a running credit of 0, 5, 10 or 15 cents and, once the credit reaches 15 cents, raises a release signal for the product chute. No change is returned: a ten-cent coin that would carry the total past 15 cents simply leaves it at 15. After the release is raised, the block stays in the paid state, whatever coins arrive, until it is reset.

Each coin arrives as a one-cycle strobe on one of two inputs. The release output comes straight from a flip-flop. It is computed from the present credit and the coin strobes, so it rises on the same clock edge that moves the credit to 15 cents. It is never decoded from the credit after that edge. A parameter selects how the credit is stored: as a two-bit binary code or as four one-hot flip-flops. Both settings behave the same at the ports.

Top module: `coin_release_ctrl`

## Requirements
- R1: Synchronous active-high reset: one clock edge with `rst` high returns the credit to 0 cents and drives `open_o` to 0 after that edge. Any coin strobe present during that edge is ignored.
- R2: A clock edge with neither strobe high leaves the credit unchanged, so `open_o` keeps its value.
- R3: A `nickel` strobe adds 5 cents to the credit: 0 goes to 5, 5 to 10, and 10 to 15.
- R4: A `dime` strobe adds 10 cents to the credit and saturates at 15 with no change returned: 0 goes to 10, while 5 and 10 both go to 15.
- R5: `open_o` is 1 exactly when the credit is 15 cents. It rises after the same clock edge that samples the coin completing the payment, with no extra cycle of delay.
- R6: Once the credit is 15 cents, `open_o` stays 1 whatever the strobes do, until a reset.
- R7: If `nickel` and `dime` are high in the same cycle, the event counts as a single dime.
- R8: Parameter `ONEHOT` = 0 stores the credit in two bits (00 for 0 cents, 01 for 5, 10 for 10, 11 for 15). `ONEHOT` = 1 stores it in four flip-flops with exactly one set (bit0 for 0 cents, bit1 for 5, bit2 for 10, bit3 for 15). The port behaviour is identical for both settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to 0 cents |
| nickel | input | 1 | One-cycle strobe for a five-cent coin |
| dime | input | 1 | One-cycle strobe for a ten-cent coin |
| open_o | output | 1 | Registered release signal, high while 15 cents are held |

## Verification
Every sequence of six coin events is swept, where each event is one of four kinds: no coin, a nickel, a dime, or both strobes together. Both storage encodings run side by side against an arithmetic credit model. The idle events show that the credit holds. Nickel and dime events tell the 5-cent and 10-cent increments apart, and they show where saturation at 15 cents sets in. The combined-strobe events show that this case is taken as a dime rather than as 15 cents, and events that arrive after payment show that the paid state is sticky. A reset issued together with a coin strobe shows that the coin is dropped.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Credit codes; the binary setting stores these values directly
    typedef enum logic [1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_e;

    // Coin event decoded from the two strobes
    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10
    } coin_e;

    localparam int unsigned NUM_CREDIT = 4;

    // Next credit for a given coin, saturating at 15 cents
    function automatic credit_e credit_step(credit_e cur, coin_e coin);
        credit_e nxt;
        nxt = cur;
        unique case (cur)
            CR_0:  if (coin == COIN_NICKEL) nxt = CR_5;
                   else if (coin == COIN_DIME) nxt = CR_10;
            CR_5:  if (coin == COIN_NICKEL) nxt = CR_10;
                   else if (coin == COIN_DIME) nxt = CR_15;
            CR_10: if (coin != COIN_NONE) nxt = CR_15;
            CR_15: nxt = CR_15;
            default: nxt = CR_0;
        endcase
        return nxt;
    endfunction

    // One-hot vector to credit code (bit index equals code value)
    function automatic credit_e credit_from_hot(logic [NUM_CREDIT-1:0] hot);
        credit_e c;
        c = CR_0;
        for (int i = 0; i < NUM_CREDIT; i++) begin
            if (hot[i]) c = credit_e'(i[1:0]);
        end
        return c;
    endfunction

endpackage

// File: rtl/coin_sense.sv
module coin_sense
    import vend_pkg::*;
(
    input  logic  nickel,
    input  logic  dime,
    output coin_e coin
);
    // Dime wins when both strobes are high
    always_comb begin
        if (dime)        coin = COIN_DIME;
        else if (nickel) coin = COIN_NICKEL;
        else             coin = COIN_NONE;
    end
endmodule

// File: rtl/credit_store.sv
module credit_store
    import vend_pkg::*;
#(
    parameter bit ONEHOT = 1'b0,
    localparam int unsigned SW = ONEHOT ? NUM_CREDIT : 2
)(
    input  logic          clk,
    input  logic          rst,
    input  coin_e         coin,
    output credit_e       credit,
    output logic [SW-1:0] state_raw,
    output logic          paid_next
);
    logic [SW-1:0] state_q;
    logic [SW-1:0] state_d;

    generate
        if (ONEHOT) begin : g_hot
            logic is_n, is_d, idle;
            assign is_n = (coin == COIN_NICKEL);
            assign is_d = (coin == COIN_DIME);
            assign idle = (coin == COIN_NONE);

            // Each bit depends only on its predecessor bits
            always_comb begin
                if (rst) begin
                    state_d = '0;
                    state_d[0] = 1'b1;
                end else begin
                    state_d[0] = state_q[0] & idle;
                    state_d[1] = (state_q[1] & idle) | (state_q[0] & is_n);
                    state_d[2] = (state_q[2] & idle) | (state_q[0] & is_d)
                               | (state_q[1] & is_n);
                    state_d[3] = state_q[3] | (state_q[2] & (is_n | is_d))
                               | (state_q[1] & is_d);
                end
            end
            assign credit    = credit_from_hot(state_q);
            assign paid_next = state_d[3];
        end else begin : g_bin
            always_comb begin
                if (rst) state_d = '0;
                else     state_d = credit_step(credit_e'(state_q), coin);
            end
            assign credit    = credit_e'(state_q);
            assign paid_next = (credit_e'(state_d) == CR_15);
        end
    endgenerate

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state_raw = state_q;
endmodule

// File: rtl/release_reg.sv
module release_reg (
    input  logic clk,
    input  logic rst,
    input  logic paid_next,
    output logic open_q
);
    // Retimed output flop: loads the decode of the next state
    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= paid_next;
    end
endmodule

// File: rtl/coin_release_ctrl.sv
module coin_release_ctrl
    import vend_pkg::*;
#(
    parameter bit ONEHOT = 1'b0
)(
    input  logic clk,
    input  logic rst,
    input  logic nickel,
    input  logic dime,
    output logic open_o
);
    localparam int unsigned SW = ONEHOT ? NUM_CREDIT : 2;

    coin_e         coin;
    credit_e       credit;
    logic [SW-1:0] state_raw;
    logic          paid_next;

    coin_sense u_sense (
        .nickel (nickel),
        .dime   (dime),
        .coin   (coin)
    );

    credit_store #(.ONEHOT(ONEHOT)) u_store (
        .clk       (clk),
        .rst       (rst),
        .coin      (coin),
        .credit    (credit),
        .state_raw (state_raw),
        .paid_next (paid_next)
    );

    release_reg u_rel (
        .clk       (clk),
        .rst       (rst),
        .paid_next (paid_next),
        .open_q    (open_o)
    );
endmodule

// File: rtl/release_checker.sv
module release_checker
    import vend_pkg::*;
#(
    parameter bit ONEHOT = 1'b0,
    localparam int unsigned SW = ONEHOT ? NUM_CREDIT : 2
)(
    input logic          clk,
    input logic          rst,
    input logic          nickel,
    input logic          dime,
    input logic          open_o,
    input credit_e       credit,
    input logic [SW-1:0] state_raw
);
    // R1: first edge after reset finds the release low
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !open_o);

    // R2: idle cycle keeps the output
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!nickel && !dime) |=> $stable(open_o));

    // R5: output register agrees with the stored credit
    p_open_tracks_credit_r5: assert property (@(posedge clk) disable iff (rst)
        open_o == (credit == CR_15));

    // R5: a rise needs a coin in the cycle before
    p_rise_needs_coin_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(nickel || dime));

    // R6: paid state is sticky
    p_sticky_open_r6: assert property (@(posedge clk) disable iff (rst)
        open_o |=> open_o);

    generate
        if (ONEHOT) begin : g_hot_chk
            // R8: exactly one flop set in the one-hot setting
            p_single_hot_r8: assert property (@(posedge clk) disable iff (rst)
                $countones(state_raw) == 1);
        end else begin : g_bin_chk
            // R8: binary code equals the credit value
            p_bin_code_r8: assert property (@(posedge clk) disable iff (rst)
                state_raw == SW'(credit));
        end
    endgenerate
endmodule

bind coin_release_ctrl release_checker #(.ONEHOT(ONEHOT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nickel    (nickel),
    .dime      (dime),
    .open_o    (open_o),
    .credit    (credit),
    .state_raw (state_raw)
);

// File: tb/test_coin_release_ctrl.sv
`timescale 1ns/1ps
module test_coin_release_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_bin, open_hot;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    coin_release_ctrl #(.ONEHOT(1'b0)) i_coin_release_ctrl (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .open_o(open_bin)
    );
    coin_release_ctrl #(.ONEHOT(1'b1)) i_coin_release_ctrl_hot (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .open_o(open_hot)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // Both encodings checked; the second also covers R8
    task automatic chk_both(input logic exp, input string tag);
        chk(open_bin, exp, {tag, " binary R8"});
        chk(open_hot, exp, {tag, " one-hot R8"});
    endtask

    // Drive away from the edge, sample 1 ns after the rising edge
    task automatic cycle(input logic r, input logic n, input logic d);
        @(negedge clk);
        rst = r; nickel = n; dime = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int credit;
        // Reset held from time zero, with a dime present: must be dropped (R1)
        cycle(1'b1, 1'b0, 1'b1);
        chk_both(1'b0, "R1 reset with dime");
        // Two nickels after that reset: 10 cents, still closed if dime was dropped
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        chk_both(1'b0, "R1 coin during reset ignored");
        cycle(1'b0, 1'b1, 1'b0);
        chk_both(1'b1, "R5 third nickel opens");
        // Reset while open clears it (R1)
        cycle(1'b1, 1'b0, 1'b0);
        chk_both(1'b0, "R1 reset clears open");

        // Exhaustive six-event sweep: 0 none, 1 nickel, 2 dime, 3 both
        for (int code = 0; code < 4096; code++) begin
            cycle(1'b1, 1'b0, 1'b0);
            chk_both(1'b0, "R1 reset state");
            credit = 0;
            for (int k = 0; k < 6; k++) begin
                int kind;
                string tag;
                kind = (code >> (2 * k)) & 3;
                if (credit >= 15)   tag = "R6 held after paid";
                else if (kind == 0) tag = "R2 idle holds";
                else if (kind == 1) tag = "R3 nickel";
                else if (kind == 2) tag = "R4 dime";
                else                tag = "R7 both as dime";
                if (kind == 1)      credit = credit + 5;
                else if (kind >= 2) credit = credit + 10;
                if (credit > 15)    credit = 15;
                cycle(1'b0, kind[0], kind[1]);
                // R5: open follows the credit with no extra cycle
                chk_both(credit == 15, tag);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule